// File: doc/BRIEF.md
# CCM Authenticate-and-Encrypt Sequencer

This block drives the authenticate-and-encrypt step of CCM mode around an external single-block AES encryption engine. It takes 128-bit formatted blocks one at a time. It folds each block into a CBC-MAC chain. For every block that carries payload it also encrypts a counter block, and XORs the result with that block to form ciphertext. When the last formatted block has been chained, it encrypts counter block zero. That value masks the final chain value, and the result is the authentication tag.

One AES engine serves both uses. The engine is reached through a start/done handshake that allows one request at a time. The sequencer holds a job kind with each request and uses it to route the result: to the chain register, to the ciphertext output, or to the tag output. The engine is never started while key expansion has not reported completion.

Block formatting, key expansion and the AES rounds are outside this block. The caller states which block index starts the payload, how many bytes of the final payload block are valid, and how many tag bytes to keep. These settings and the nonce are held stable for the whole message.

Top module: `ccm_seq`

## Requirements
- R1: After reset, blk_ready is high, and aes_start, ct_valid, ct_last and tag_valid are low.
- R2: aes_start is never high while key_ready is low. A pending request waits until key_ready rises.
- R3: Only one engine request is outstanding at a time. After aes_start, no further aes_start occurs until aes_done has been seen.
- R4: The chain starts at zero for each message. For each block B the engine input is chain XOR B, and the engine result becomes the new chain value.
- R5: A counter block is laid out from the most significant byte downward. Byte 0 holds CNT_BYTES-1. The next 15-CNT_BYTES bytes hold the nonce. The last CNT_BYTES bytes hold a big-endian count. The count is 0 for the tag mask, and 1, 2, … for successive payload blocks.
- R6: Blocks are numbered from 0. Each block whose index is at least pay_first produces exactly one ct_valid pulse, with ct_data = block XOR E(counter block). Blocks below pay_first produce no ciphertext.
- R7: For the final block of a message, only the leading pay_last_bytes bytes of ciphertext are kept (values 1 to 16), and the rest are zero. Ciphertext from other payload blocks keeps all 16 bytes.
- R8: tag_valid pulses once per message with tag_data = final chain XOR E(counter block 0). The leading mac_len bytes are kept and the remaining bytes are zero.
- R9: For every block, the chain request is issued before that block's counter request. The tag-mask request comes last. blk_ready stays low from acceptance until all of the block's engine work is done.
- R10: ct_last is high with the ciphertext of the message's final block and low with all other ciphertext.
- R11: A message that follows another one restarts the chain at zero and the count at zero. Repeating a message gives the same ciphertext and the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_ready | input | 1 | Key expansion complete; engine may be started |
| blk_valid | input | 1 | Formatted block offered |
| blk_ready | output | 1 | Sequencer can accept a block |
| blk_data | input | 128 | Formatted block, byte 0 in bits 127:120 |
| blk_last | input | 1 | Offered block is the last of the message |
| nonce | input | 8*(15-CNT_BYTES) | Nonce placed in counter blocks |
| mac_len | input | 5 | Tag bytes kept, 1 to 16 |
| pay_first | input | IDX_W | Index of the first payload block |
| pay_last_bytes | input | 5 | Valid bytes in the final payload block, 1 to 16 |
| aes_start | output | 1 | Engine request, one cycle |
| aes_in | output | 128 | Engine input block, stable while the request waits |
| aes_done | input | 1 | Engine result valid, one cycle |
| aes_out | input | 128 | Engine result |
| ct_valid | output | 1 | Ciphertext block valid, one cycle |
| ct_data | output | 128 | Ciphertext block |
| ct_last | output | 1 | Ciphertext belongs to the final block |
| tag_valid | output | 1 | Tag valid, one cycle |
| tag_data | output | 128 | Truncated tag, unused bytes zero |

## Verification
The bench uses the default parameters: a 2-byte counter field with a 13-byte nonce, and an 8-bit block index. With these values, messages of two to five blocks are quick to run, and counter values in the exact byte positions of R5 can be checked. The engine is modelled by a simple invertible-looking mixing function whose latency changes between tests. This lets the bench predict every engine input and result, in order. The stimulus covers these cases:
- a full final block and a short final block;
- payload that starts right after block 0, and a message with no payload at all;
- tag lengths of 16, 8 and 4 bytes;
- key_ready held low while a request waits;
- the same message sent twice back to back.

// File: rtl/ccm_pkg.sv
// Shared types for the CCM sequencer.
// Assumes: 128-bit blocks, byte 0 held in the top byte.
package ccm_pkg;
    localparam int BLK_BYTES = 16;
    localparam int BLK_W     = 8 * BLK_BYTES;

    // Kind of engine request; decides where the result goes.
    typedef enum logic [1:0] {
        JOB_CHAIN  = 2'd0,
        JOB_STREAM = 2'd1,
        JOB_MASK   = 2'd2
    } job_t;

    // Sequencer control state.
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } seq_st_t;
endpackage

// File: rtl/ccm_ctr_gen.sv
// Builds a 128-bit counter block as {CNT_BYTES-1, nonce, count}.
// The count is big-endian in the low CNT_BYTES bytes.
// Assumes: 2 <= CNT_BYTES <= 8.
module ccm_ctr_gen #(
    parameter int CNT_BYTES = 2
) (
    input  logic [8*(15-CNT_BYTES)-1:0] nonce,
    input  logic [8*CNT_BYTES-1:0]      count,
    output logic [127:0]                blk
);
    localparam logic [7:0] FLAGS = 8'(CNT_BYTES - 1);

    // Concatenate the flags byte, the nonce and the count.
    always_comb begin
        blk = {FLAGS, nonce, count};
    end
endmodule

// File: rtl/ccm_byte_mask.sv
// Produces a byte-keep mask: the leading NB bytes are ones, the rest zero.
// Assumes: nbytes is in 0..16. Byte 0 is bits 127:120.
module ccm_byte_mask (
    input  logic [4:0]   nbytes,
    output logic [127:0] mask
);
    for (genvar j = 0; j < 16; j++) begin : g_byte
        // Keep byte j when it falls inside the leading count.
        assign mask[127-8*j -: 8] = (nbytes > 5'(j)) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/ccm_ctrl.sv
// Control FSM for the sequencer.
// Accepts one block at a time, then issues engine requests in a fixed order:
// first the chain request, then the keystream request if the block carries
// payload, then the tag-mask request if the block is the last one.
// The job kind held here routes each engine result.
// Assumes: the engine answers each start with exactly one done.
module ccm_ctrl
    import ccm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_valid,
    input  logic blk_last,
    input  logic is_payload,
    input  logic key_ready,
    input  logic aes_done,
    output logic blk_ready,
    output logic accept,
    output logic aes_start,
    output job_t job,
    output logic last_q,
    output logic res_chain,
    output logic res_stream,
    output logic res_mask
);
    seq_st_t st;
    logic    pay_q;
    logic    pend;

    // Handshake and request strobes derived from the state.
    always_comb begin
        blk_ready  = (st == S_IDLE);
        accept     = blk_ready && blk_valid;
        aes_start  = (st == S_REQ) && key_ready;
        res_chain  = (st == S_WAIT) && aes_done && (job == JOB_CHAIN);
        res_stream = (st == S_WAIT) && aes_done && (job == JOB_STREAM);
        res_mask   = (st == S_WAIT) && aes_done && (job == JOB_MASK);
    end

    // State, job kind and per-block flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            job    <= JOB_CHAIN;
            last_q <= 1'b0;
            pay_q  <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (accept) begin
                        job    <= JOB_CHAIN;
                        last_q <= blk_last;
                        pay_q  <= is_payload;
                        st     <= S_REQ;
                    end
                end
                S_REQ: begin
                    if (key_ready) st <= S_WAIT;
                end
                S_WAIT: begin
                    if (aes_done) begin
                        case (job)
                            JOB_CHAIN: begin
                                if (pay_q) begin
                                    job <= JOB_STREAM;
                                    st  <= S_REQ;
                                end else if (last_q) begin
                                    job <= JOB_MASK;
                                    st  <= S_REQ;
                                end else begin
                                    st  <= S_IDLE;
                                end
                            end
                            JOB_STREAM: begin
                                if (last_q) begin
                                    job <= JOB_MASK;
                                    st  <= S_REQ;
                                end else begin
                                    st  <= S_IDLE;
                                end
                            end
                            default: st <= S_IDLE;
                        endcase
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Outstanding-request tracker, seen from the handshake pins.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (aes_start) pend <= 1'b1;
        else if (aes_done)  pend <= 1'b0;
    end

    // R3: no second start while a request is outstanding
    p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !aes_done) |-> !aes_start);

    // R2: a waiting request holds, and nothing is launched, without key_ready
    p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_REQ && !key_ready) |=> (st == S_REQ && !pend));

    // R9: an accepted block blocks further input on the next cycle
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !blk_ready);
endmodule

// File: rtl/ccm_seq.sv
// CCM authenticate-and-encrypt sequencer.
// Chains formatted blocks through CBC-MAC and encrypts counter blocks with
// one shared AES engine. It emits masked ciphertext and a truncated tag.
// Assumes: nonce, mac_len, pay_first and pay_last_bytes stay stable during
// a message, and pay_first >= 1.
module ccm_seq
    import ccm_pkg::*;
#(
    parameter int CNT_BYTES = 2,
    parameter int IDX_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        key_ready,
    input  logic                        blk_valid,
    output logic                        blk_ready,
    input  logic [127:0]                blk_data,
    input  logic                        blk_last,
    input  logic [8*(15-CNT_BYTES)-1:0] nonce,
    input  logic [4:0]                  mac_len,
    input  logic [IDX_W-1:0]            pay_first,
    input  logic [4:0]                  pay_last_bytes,
    output logic                        aes_start,
    output logic [127:0]                aes_in,
    input  logic                        aes_done,
    input  logic [127:0]                aes_out,
    output logic                        ct_valid,
    output logic [127:0]                ct_data,
    output logic                        ct_last,
    output logic                        tag_valid,
    output logic [127:0]                tag_data
);
    localparam int CNT_W = 8 * CNT_BYTES;

    logic [127:0]     blk_q;
    logic [127:0]     chain_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             in_msg;
    logic [4:0]       nbytes_q;
    logic [IDX_W-1:0] cur_idx;
    logic             is_payload;
    logic             accept;
    logic             last_q;
    logic             res_chain, res_stream, res_mask;
    job_t             job;
    logic [CNT_W-1:0] ctr_count;
    logic [127:0]     ctr_blk;
    logic [127:0]     ct_keep;
    logic [127:0]     tag_keep;

    // Index of the offered block and whether it carries payload.
    always_comb begin
        cur_idx    = in_msg ? idx_q : '0;
        is_payload = (cur_idx >= pay_first);
    end

    ccm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_valid  (blk_valid),
        .blk_last   (blk_last),
        .is_payload (is_payload),
        .key_ready  (key_ready),
        .aes_done   (aes_done),
        .blk_ready  (blk_ready),
        .accept     (accept),
        .aes_start  (aes_start),
        .job        (job),
        .last_q     (last_q),
        .res_chain  (res_chain),
        .res_stream (res_stream),
        .res_mask   (res_mask)
    );

    // Counter value: zero for the tag mask, else the running payload count.
    always_comb begin
        ctr_count = (job == JOB_MASK) ? '0 : cnt_q;
    end

    ccm_ctr_gen #(.CNT_BYTES(CNT_BYTES)) u_ctr (
        .nonce (nonce),
        .count (ctr_count),
        .blk   (ctr_blk)
    );

    ccm_byte_mask u_ct_mask (
        .nbytes (nbytes_q),
        .mask   (ct_keep)
    );

    ccm_byte_mask u_tag_mask (
        .nbytes (mac_len),
        .mask   (tag_keep)
    );

    // Engine input: chain XOR block for chain work, else the counter block.
    always_comb begin
        aes_in = (job == JOB_CHAIN) ? (chain_q ^ blk_q) : ctr_blk;
    end

    // Block capture, message position, chain and counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q    <= '0;
            chain_q  <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            in_msg   <= 1'b0;
            nbytes_q <= 5'd16;
        end else begin
            if (accept) begin
                blk_q    <= blk_data;
                idx_q    <= cur_idx + 1'b1;
                in_msg   <= !blk_last;
                nbytes_q <= blk_last ? pay_last_bytes : 5'd16;
                if (!in_msg) begin
                    chain_q <= '0;
                    cnt_q   <= is_payload ? CNT_W'(1) : '0;
                end else if (is_payload) begin
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
            if (res_chain) chain_q <= aes_out;
        end
    end

    // Ciphertext and tag outputs, one-cycle valid pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_valid  <= 1'b0;
            ct_data   <= '0;
            ct_last   <= 1'b0;
            tag_valid <= 1'b0;
            tag_data  <= '0;
        end else begin
            ct_valid  <= res_stream;
            tag_valid <= res_mask;
            if (res_stream) begin
                ct_data <= (blk_q ^ aes_out) & ct_keep;
                ct_last <= last_q;
            end
            if (res_mask) tag_data <= (chain_q ^ aes_out) & tag_keep;
        end
    end

    // R6: one ciphertext pulse per keystream result
    p_ct_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |=> !ct_valid);

    // R7: bytes past the valid count are zero
    p_ct_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> ((ct_data & ~ct_keep) == '0));

    // R8: tag bytes past mac_len are zero
    p_tag_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> ((tag_data & ~tag_keep) == '0));

    // R9: the tag comes after the message's ciphertext, never with it
    p_tag_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> !ct_valid);
endmodule

// File: tb/tb_ccm_seq.sv
// Directed bench for ccm_seq, with a behavioural AES engine model.
module tb_ccm_seq;
    localparam int CNT_BYTES = 2;
    localparam int IDX_W     = 8;
    localparam int NW        = 8 * (15 - CNT_BYTES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             key_ready = 1'b0;
    logic             blk_valid = 1'b0;
    logic             blk_ready;
    logic [127:0]     blk_data = '0;
    logic             blk_last = 1'b0;
    logic [NW-1:0]    nonce = '0;
    logic [4:0]       mac_len = 5'd16;
    logic [IDX_W-1:0] pay_first = 8'd1;
    logic [4:0]       pay_last_bytes = 5'd16;
    logic             aes_start;
    logic [127:0]     aes_in;
    logic             aes_done = 1'b0;
    logic [127:0]     aes_out = '0;
    logic             ct_valid, ct_last, tag_valid;
    logic [127:0]     ct_data, tag_data;

    int tests = 0;
    int fails = 0;

    ccm_seq #(.CNT_BYTES(CNT_BYTES), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .key_ready(key_ready),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
        .blk_last(blk_last), .nonce(nonce), .mac_len(mac_len),
        .pay_first(pay_first), .pay_last_bytes(pay_last_bytes),
        .aes_start(aes_start), .aes_in(aes_in), .aes_done(aes_done),
        .aes_out(aes_out), .ct_valid(ct_valid), .ct_data(ct_data),
        .ct_last(ct_last), .tag_valid(tag_valid), .tag_data(tag_data)
    );

    always #2.5 clk = ~clk;

    // Stand-in block cipher.
    function automatic logic [127:0] fx(input logic [127:0] x);
        logic [127:0] r;
        r = {x[114:0], x[127:115]} ^ 128'hA5C3_0F1E_9B27_6D48_3C5A_E1F0_7B92_D4E6;
        return r + 128'h0000_1234_0000_5678_0000_9ABC_0000_DEF1;
    endfunction

    function automatic logic [127:0] ctrb(input logic [NW-1:0] n, input int k);
        return {8'(CNT_BYTES - 1), n, 16'(k)};
    endfunction

    function automatic logic [127:0] keep(input int nb);
        logic [127:0] m;
        m = '0;
        for (int j = 0; j < 16; j++) if (j < nb) m[127-8*j -: 8] = 8'hFF;
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Engine model and logs.
    int           lat = 3;
    int           cd = 0;
    bit           pend = 0;
    logic [127:0] held;
    logic [127:0] in_log [0:31];
    int           n_in = 0;
    logic [127:0] ct_log [0:15];
    bit           ctl_log [0:15];
    int           n_ct = 0;
    logic [127:0] tag_got;
    int           n_tag = 0;

    always @(negedge clk) begin
        aes_done <= 1'b0;
        if (rst_n && aes_start) begin
            check(!pend, "R3", 128'(pend), 128'(0));
            check(key_ready, "R2", 128'(key_ready), 128'(1));
            if (n_in < 32) in_log[n_in] = aes_in;
            n_in++;
            held = aes_in;
            pend = 1;
            cd = lat;
        end else if (pend) begin
            cd--;
            if (cd <= 0) begin
                aes_done <= 1'b1;
                aes_out  <= fx(held);
                pend = 0;
            end
        end
        if (rst_n && ct_valid) begin
            if (n_ct < 16) begin
                ct_log[n_ct]  = ct_data;
                ctl_log[n_ct] = ct_last;
            end
            n_ct++;
        end
        if (rst_n && tag_valid) begin
            tag_got = tag_data;
            n_tag++;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    logic [127:0] blks [0:7];

    // Sends n blocks, waits for the tag, then checks everything against the model.
    task automatic run_msg(input int n, input int pf, input int lb, input int ml,
                           input int kdelay, input string name);
        logic [127:0] ch, exp_in [0:31], exp_ct [0:15], tg;
        bit           exp_l [0:15];
        int ne, nc, k, waitc;
        n_in = 0; n_ct = 0; n_tag = 0;
        pay_first = 8'(pf); pay_last_bytes = 5'(lb); mac_len = 5'(ml);
        ch = '0; ne = 0; nc = 0; k = 0;
        for (int i = 0; i < n; i++) begin
            exp_in[ne] = ch ^ blks[i]; ne++;
            ch = fx(ch ^ blks[i]);
            if (i >= pf) begin
                k++;
                exp_in[ne] = ctrb(nonce, k); ne++;
                exp_ct[nc] = (blks[i] ^ fx(ctrb(nonce, k))) & keep((i == n-1) ? lb : 16);
                exp_l[nc] = (i == n-1);
                nc++;
            end
        end
        exp_in[ne] = ctrb(nonce, 0); ne++;
        tg = (ch ^ fx(ctrb(nonce, 0))) & keep(ml);
        if (kdelay > 0) key_ready = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!blk_ready) @(negedge clk);
            blk_valid = 1'b1; blk_data = blks[i]; blk_last = (i == n-1);
            @(negedge clk);
            blk_valid = 1'b0;
            if (i == 0 && kdelay > 0) begin
                repeat (kdelay) @(negedge clk);
                check(n_in == 0, "R2", 128'(n_in), 128'(0));
                check(!blk_ready, "R9", 128'(blk_ready), 128'(0));
                key_ready = 1'b1;
            end
        end
        waitc = 0;
        while (n_tag == 0 && waitc < 2000) begin
            @(negedge clk); waitc++;
        end
        repeat (4) @(negedge clk);
        $display("[TB] scenario %s", name);
        check(n_in == ne, "R9", 128'(n_in), 128'(ne));
        for (int i = 0; i < ne && i < n_in; i++)
            check(in_log[i] === exp_in[i], (i == ne-1) ? "R5" : "R4", in_log[i], exp_in[i]);
        check(n_ct == nc, "R6", 128'(n_ct), 128'(nc));
        for (int i = 0; i < nc && i < n_ct; i++) begin
            check(ct_log[i] === exp_ct[i], (i == nc-1) ? "R7" : "R6", ct_log[i], exp_ct[i]);
            check(ctl_log[i] == exp_l[i], "R10", 128'(ctl_log[i]), 128'(exp_l[i]));
        end
        check(n_tag == 1, "R8", 128'(n_tag), 128'(1));
        check(tag_got === tg, "R8", tag_got, tg);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(blk_ready === 1'b1, "R1", 128'(blk_ready), 128'(1));
        check(aes_start === 1'b0, "R1", 128'(aes_start), 128'(0));
        check(ct_valid === 1'b0 && ct_last === 1'b0, "R1", 128'({ct_valid, ct_last}), 128'(0));
        check(tag_valid === 1'b0, "R1", 128'(tag_valid), 128'(0));
    endtask

    task automatic t_full_payload();
        lat = 3;
        run_msg(4, 2, 16, 16, 0, "assoc then two full payload blocks");
    endtask

    task automatic t_short_tail();
        lat = 1;
        run_msg(5, 1, 5, 8, 0, "short final block, 8-byte tag");
    endtask

    task automatic t_no_payload();
        lat = 2;
        run_msg(2, 5, 16, 4, 0, "no payload, 4-byte tag");
    endtask

    task automatic t_key_wait();
        lat = 4;
        run_msg(3, 1, 16, 16, 12, "key_ready late");
    endtask

    task automatic t_repeat();
        logic [127:0] first_tag, first_ct;
        lat = 2;
        run_msg(3, 1, 9, 12, 0, "message once");
        first_tag = tag_got; first_ct = ct_log[0];
        run_msg(3, 1, 9, 12, 0, "same message again");
        check(tag_got === first_tag, "R11", tag_got, first_tag);
        check(ct_log[0] === first_ct, "R11", ct_log[0], first_ct);
    endtask

    initial begin
        for (int i = 0; i < 8; i++)
            blks[i] = {32'h1357_9BDF + 32'(i * 32'h0101_0101), 32'hC0DE_0000 | 32'(i),
                       32'h8000_0001 ^ 32'(i << 7), 32'h55AA_33CC + 32'(i)};
        nonce = 104'h0102_0304_0506_0708_090A_0B0C_0D;
        key_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_payload();
        t_short_tail();
        t_no_payload();
        t_key_wait();
        t_repeat();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule